// File: doc/BRIEF.md
# DDR Read Strobe Polarity Selector

This block settles, once per read burst, which edge of the system clock the read synchronizing registers use to take data captured on the delayed DQS strobe. The phase between the delayed strobe and the system clock is treated as unknown. It is therefore measured again at the start of each read rather than fixed at build time.

A read-start pulse arms the block. It then waits until DQS is driven and seen low, which marks the preamble. The first rising DQS edge after that, while DQS is still driven, is the trigger. At the trigger the block latches the level of the system clock. A high level selects the falling edge and a low level selects the rising edge. The trigger crosses into the system clock domain through a two-flop synchronizer. The choice is then published on `pol_fall` with a done flag. A re-timer registers the captured read data on the selected edge and presents it on the rising edge with a valid strobe.

The controlling state machine has four states. `S_IDLE` waits for the first read. `S_WAIT_LOW` waits for a driven low preamble. `S_ARMED` waits for the synchronized trigger. `S_LOCKED` holds the decision. Its transitions are as follows:
- `S_IDLE`→`S_WAIT_LOW` on read start.
- `S_WAIT_LOW`→`S_ARMED` when the synchronized preamble level is seen.
- `S_ARMED`→`S_LOCKED` when the trigger token returns.
- Any of `S_WAIT_LOW`, `S_ARMED` or `S_LOCKED` → `S_WAIT_LOW` on read start.

Top module: `rdq_polarity_sel`

## Requirements
- R1: After synchronous reset `pol_fall` is 0 (rising edge), `pol_done` is 0 and `rt_valid` is 0.
- R2: A `rd_start` pulse makes `pol_done` 0 at the next rising clock edge. `pol_fall` keeps its previous value until a new decision is made.
- R3: Rising edges of `dqs_dly` while `dqs_drv` is 0 never trigger a decision, even after the preamble has been seen.
- R4: A rising edge of `dqs_dly` that follows a low too short to be seen at any rising clock edge since `rd_start` does not trigger a decision.
- R5: The trigger is the first rising edge of `dqs_dly` that follows a low preamble seen while `dqs_drv` is 1. If `clk` is high at the trigger, `pol_fall` becomes 1. If `clk` is low at the trigger, `pol_fall` becomes 0.
- R6: Once `pol_done` is 1, further DQS edges leave `pol_fall` unchanged. `pol_fall` changes only in the cycle in which `pol_done` rises.
- R7: The trigger passes through a two-flop synchronizer. `pol_done` is 1 no later than the fourth rising clock edge after the trigger edge.
- R8: With `pol_done` 1, `cap_vld`/`cap_data` are driven just after rising edge P0 and held for one cycle. With `pol_fall`=0 they appear on `rt_valid`/`rt_data` after rising edge P2. With `pol_fall`=1 they appear after P1. In both cases `rt_valid` is 1 for exactly one cycle.
- R9: While `pol_done` is 0, `rt_valid` stays 0 whatever `cap_vld` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| rd_start | input | 1 | One-cycle pulse at the start of each read |
| dqs_dly | input | 1 | Delayed read strobe |
| dqs_drv | input | 1 | 1 while the memory drives the strobe |
| cap_vld | input | 1 | Valid for the data captured on the strobe |
| cap_data | input | DATA_W | Data captured on the strobe |
| pol_fall | output | 1 | Selected edge: 1 = falling, 0 = rising |
| pol_done | output | 1 | Polarity decision for this read is valid |
| rt_valid | output | 1 | Re-timed data valid |
| rt_data | output | DATA_W | Re-timed data |

## Verification
The assertions check on every cycle that a read start clears the done flag, and that the polarity moves only in the cycle the flag rises. They also check that a lock is only ever entered from the armed state, that re-timed data never shows as valid without a decision, and that the synchronizer shifts by one stage per clock. Only the bench scenarios can show the clock-phase sampling itself: they place trigger edges in the high and the low half of the clock. They also show that undriven and glitch edges are rejected, the lock latency, and the different re-timing latency of each polarity.

// File: rtl/rdq_pkg.sv
package rdq_pkg;
    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_WAIT_LOW = 2'd1,
        S_ARMED    = 2'd2,
        S_LOCKED   = 2'd3
    } rdq_state_t;
endpackage

// File: rtl/rdq_sync.sv
module rdq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

    generate
        if (STAGES >= 2) begin : g_chk
            // R7: each clock moves the token exactly one stage
            a_r7_sync_shift: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (q == $past(stg[STAGES-2])));
        end
    endgenerate
endmodule

// File: rtl/rdq_edge_catch.sv
module rdq_edge_catch (
    input  logic dqs_dly,
    input  logic rst,
    input  logic dqs_drv,
    input  logic arm_en,
    input  logic arm_tog,
    input  logic sys_lvl,
    output logic hit_tog,
    output logic phase_cap
);
    // Strobe-domain capture: accepts one edge per arm token.
    always_ff @(posedge dqs_dly or posedge rst) begin
        if (rst) begin
            hit_tog   <= 1'b0;
            phase_cap <= 1'b0;
        end else if (arm_en && dqs_drv && (hit_tog != arm_tog)) begin
            hit_tog   <= arm_tog;
            phase_cap <= sys_lvl;
        end
    end
endmodule

// File: rtl/rdq_retime.sv
module rdq_retime #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pol_fall,
    input  logic         pol_done,
    input  logic         cap_vld,
    input  logic [W-1:0] cap_data,
    output logic         rt_valid,
    output logic [W-1:0] rt_data
);
    logic         pos_v, neg_v;
    logic [W-1:0] pos_d, neg_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_v <= 1'b0;
            pos_d <= '0;
        end else begin
            pos_v <= cap_vld;
            pos_d <= cap_data;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            neg_v <= 1'b0;
            neg_d <= '0;
        end else begin
            neg_v <= cap_vld;
            neg_d <= cap_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rt_valid <= 1'b0;
            rt_data  <= '0;
        end else begin
            rt_valid <= pol_done && (pol_fall ? neg_v : pos_v);
            rt_data  <= pol_fall ? neg_d : pos_d;
        end
    end
endmodule

// File: rtl/rdq_polarity_sel.sv
module rdq_polarity_sel
    import rdq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic              dqs_dly,
    input  logic              dqs_drv,
    input  logic              cap_vld,
    input  logic [DATA_W-1:0] cap_data,
    output logic              pol_fall,
    output logic              pol_done,
    output logic              rt_valid,
    output logic [DATA_W-1:0] rt_data
);
    rdq_state_t state, nxt;
    logic arm_tog, hit_tog, phase_cap;
    logic hit_sync, low_sync, pre_low, arm_en;

    assign pre_low = dqs_drv & ~dqs_dly;
    assign arm_en  = (state == S_ARMED);

    rdq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_low_sync (
        .clk (clk), .rst (rst), .d (pre_low), .q (low_sync)
    );

    rdq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_hit_sync (
        .clk (clk), .rst (rst), .d (hit_tog), .q (hit_sync)
    );

    rdq_edge_catch u_catch (
        .dqs_dly   (dqs_dly),
        .rst       (rst),
        .dqs_drv   (dqs_drv),
        .arm_en    (arm_en),
        .arm_tog   (arm_tog),
        .sys_lvl   (clk),
        .hit_tog   (hit_tog),
        .phase_cap (phase_cap)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (rd_start) nxt = S_WAIT_LOW;
            end
            S_WAIT_LOW: begin
                if (rd_start)      nxt = S_WAIT_LOW;
                else if (low_sync) nxt = S_ARMED;
            end
            S_ARMED: begin
                if (rd_start)                nxt = S_WAIT_LOW;
                else if (hit_sync == arm_tog) nxt = S_LOCKED;
            end
            S_LOCKED: begin
                if (rd_start) nxt = S_WAIT_LOW;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // Output process
    always_ff @(posedge clk) begin
        if (rst) begin
            pol_fall <= 1'b0;
            arm_tog  <= 1'b0;
        end else begin
            if (state == S_WAIT_LOW && nxt == S_ARMED && hit_sync == arm_tog)
                arm_tog <= ~arm_tog;
            if (state == S_ARMED && nxt == S_LOCKED)
                pol_fall <= phase_cap;
        end
    end

    assign pol_done = (state == S_LOCKED);

    rdq_retime #(.W(DATA_W)) u_retime (
        .clk      (clk),
        .rst      (rst),
        .pol_fall (pol_fall),
        .pol_done (pol_done),
        .cap_vld  (cap_vld),
        .cap_data (cap_data),
        .rt_valid (rt_valid),
        .rt_data  (rt_data)
    );

    a_r2_done_clears: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> !pol_done);

    a_r6_pol_steady: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (pol_fall != $past(pol_fall))) |-> (pol_done && !$past(pol_done)));

    a_r5_lock_from_armed: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && state == S_LOCKED && $past(state) != S_LOCKED) |-> ($past(state) == S_ARMED));

    a_r9_valid_gated: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rt_valid) |-> $past(pol_done));
endmodule

// File: tb/rdq_polarity_sel_bench.sv
`timescale 1ns/1ps
module rdq_polarity_sel_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rd_start = 1'b0;
    logic         dqs_dly = 1'b1;
    logic         dqs_drv = 1'b0;
    logic         cap_vld = 1'b0;
    logic [W-1:0] cap_data = '0;
    logic         pol_fall, pol_done, rt_valid;
    logic [W-1:0] rt_data;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  exp_pol = 1'b0;
    bit  ended   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    rdq_polarity_sel #(.DATA_W(W)) u_rdq_polarity_sel (
        .clk (clk), .rst (rst), .rd_start (rd_start),
        .dqs_dly (dqs_dly), .dqs_drv (dqs_drv),
        .cap_vld (cap_vld), .cap_data (cap_data),
        .pol_fall (pol_fall), .pol_done (pol_done),
        .rt_valid (rt_valid), .rt_data (rt_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 pol_fall", pol_fall, 0);
        chk("R1 pol_done", pol_done, 0);
        chk("R1 rt_valid", rt_valid, 0);
    endtask

    task automatic t_no_lock_data;
        @(posedge clk); #1 cap_vld = 1'b1; cap_data = 8'h3C;
        @(posedge clk); #1 cap_vld = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R9 rt_valid without decision", rt_valid, 0);
            tick(1);
        end
    endtask

    task automatic t_read(input bit hi);
        int t_trig = hi ? 4 : 14;
        int t_opp  = hi ? 14 : 4;
        @(posedge clk); #1 rd_start = 1'b1;
        @(posedge clk); #1 rd_start = 1'b0;
        chk("R2 done cleared", pol_done, 0);
        chk("R2 pol held", pol_fall, exp_pol);
        // glitch low not seen by any clock edge, driven
        dqs_drv = 1'b1; dqs_dly = 1'b1;
        @(posedge clk); #5 dqs_dly = 1'b0; #2 dqs_dly = 1'b1;
        tick(6);
        chk("R4 glitch edge ignored", pol_done, 0);
        chk("R4 pol unchanged", pol_fall, exp_pol);
        // preamble
        @(posedge clk); #8 dqs_dly = 1'b0;
        repeat (6) @(posedge clk);
        // undriven edges at the opposite phase
        #8 dqs_drv = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #(t_opp) dqs_dly = 1'b1;
            @(posedge clk); #8 dqs_dly = 1'b0;
        end
        tick(5);
        chk("R3 undriven edges ignored", pol_done, 0);
        // driven low again, then the real trigger
        dqs_drv = 1'b1;
        repeat (3) @(posedge clk);
        @(posedge clk); #(t_trig) dqs_dly = 1'b1;
        tick(4);
        chk("R7 done within 4 edges", pol_done, 1);
        exp_pol = hi;
        chk("R5 polarity from clock phase", pol_fall, exp_pol);
        // later edges at the opposite phase
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #8 dqs_dly = 1'b0;
            @(posedge clk); #(t_opp) dqs_dly = 1'b1;
        end
        tick(5);
        chk("R6 pol stable after lock", pol_fall, exp_pol);
        chk("R6 done stays", pol_done, 1);
        dqs_drv = 1'b0;
        dqs_dly = 1'b1;
    endtask

    task automatic t_retime(input logic [W-1:0] v);
        @(posedge clk); #1 cap_vld = 1'b1; cap_data = v;
        @(posedge clk); #1 cap_vld = 1'b0; cap_data = ~v;
        if (pol_fall) begin
            chk("R8 fall valid after P1", rt_valid, 1);
            chk("R8 fall data after P1", rt_data, v);
            tick(1);
            chk("R8 fall single valid", rt_valid, 0);
        end else begin
            chk("R8 rise not yet after P1", rt_valid, 0);
            tick(1);
            chk("R8 rise valid after P2", rt_valid, 1);
            chk("R8 rise data after P2", rt_data, v);
            tick(1);
            chk("R8 rise single valid", rt_valid, 0);
        end
    endtask

    initial begin
        t_reset();
        t_no_lock_data();
        t_read(1'b1);
        t_retime(8'hA5);
        t_read(1'b0);
        t_retime(8'h5A);
        t_read(1'b1);
        t_retime(8'hC3);
        ended = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!ended) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule